// File: doc/BRIEF.md
# Priority Throttle Event Arbiter

This block decides which clock-throttle setting a chip applies when several throttle causes are active at the same time. It watches four event sources: a light thermal event and a heavy thermal event, each raised by comparing a zone temperature (in millidegrees Celsius) against a programmed hot threshold with a fixed release hysteresis, and two overcurrent event lines that come straight from outside. Software programs, for every event, a priority, a CPU pulse-skip depth in percent and a GPU skip level.

Each cycle, the arbiter looks at the active and enabled events and picks the one with the largest priority. When priorities are equal, the lowest event index wins. It registers the complete settings of that event (CPU depth and GPU level) together with a valid flag. Downstream pulse skippers use these outputs directly. When nothing is active, they receive a zero setting with valid low.

Top module: `thr_arb`

## Requirements
- R1: A write with `cfg_addr` 0 to 3 stores the settings of event 0 (light), 1 (heavy), 2 (first overcurrent) or 3 (second overcurrent). The priority is taken from `cfg_wdata[6:0]`, the CPU depth in percent from `[14:8]` and the GPU level from `[17:16]`. A priority above 100 is stored as 100, and a CPU depth above 100 is stored as 100.
- R2: Among the active events, the one with the numerically largest priority wins. The outputs carry that event's CPU depth and GPU level together.
- R3: When active events share the largest priority, the event with the lowest index wins.
- R4: An event with priority 0 never wins. Every event has priority 0 after reset.
- R5: With no enabled event active, `thr_valid` is 0, `thr_cpu_pct` is 0 and `thr_gpu_lvl` is 0.
- R6: The light event (threshold at `cfg_addr` 4) and the heavy event (threshold at `cfg_addr` 5, value in `cfg_wdata[17:0]`) turn on once the zone temperature is strictly above the threshold. After reset, both thresholds are all ones, so neither event can turn on.
- R7: A thermal event that is on turns off only when its temperature is strictly below the threshold minus 1000. Between that point and the threshold, the event keeps its previous state.
- R8: An overcurrent input is an event that is active high. The outputs change on the first clock edge after an event's active state changes. Because a thermal event's state is itself registered, its outputs change on the second edge after the temperature crosses.
- R9: Asserting `rst_n` clears the outputs at once, and it returns all priorities and thresholds to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address: 0-3 event settings, 4 light threshold, 5 heavy threshold |
| cfg_wdata | input | 32 | Configuration write data |
| tz_light_temp | input | 18 | Light zone temperature, millidegrees |
| tz_heavy_temp | input | 18 | Heavy zone temperature, millidegrees |
| oc_evt | input | 2 | Overcurrent event lines, active high |
| thr_valid | output | 1 | A throttle setting is in force |
| thr_cpu_pct | output | 7 | CPU skip depth of the winning event, percent |
| thr_gpu_lvl | output | 2 | GPU skip level of the winning event |

## Verification
The bench tests equal priorities across both overcurrent events. A design that breaks ties toward the higher index, or that skips clamping, returns the second event's settings there. It drives temperatures exactly at the threshold, exactly at the release point and inside the hysteresis band. A design that uses a non-strict compare, or that forgets the held state, flips the output at the wrong sample. It also tests a disabled event that is still hot, where a design that lets priority 0 win would report valid. Finally, it checks the one-cycle overcurrent latency and the two-cycle thermal latency on both sides of the edge, and it checks that a mid-run reset clears the configuration.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;

  localparam int PRIO_W = 7;
  localparam int PCT_W  = 7;
  localparam int LVL_W  = 2;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [PCT_W-1:0]  cpu;
    logic [LVL_W-1:0]  gpu;
  } thr_set_t;

endpackage

// File: rtl/thr_arb_cfg.sv
module thr_arb_cfg
  import thr_arb_pkg::*;
#(
  parameter int N_EV     = 4,
  parameter int TEMP_W   = 18,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  parameter int PRIO_MAX = 100,
  parameter int PCT_MAX  = 100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output thr_set_t [N_EV-1:0]       sets_o,
  output logic [1:0][TEMP_W-1:0]    thr_o
);

  localparam logic [PRIO_W-1:0] PRIO_CAP = PRIO_W'(PRIO_MAX);
  localparam logic [PCT_W-1:0]  PCT_CAP  = PCT_W'(PCT_MAX);

  // clamp the incoming fields once
  logic [PRIO_W-1:0] w_prio;
  logic [PCT_W-1:0]  w_cpu;
  thr_set_t          w_set;

  always_comb begin
    w_prio = (wdata[PRIO_W-1:0] > PRIO_CAP) ? PRIO_CAP : wdata[PRIO_W-1:0];
    w_cpu  = (wdata[8+PCT_W-1:8] > PCT_CAP) ? PCT_CAP : wdata[8+PCT_W-1:8];
    w_set  = '{prio: w_prio, cpu: w_cpu, gpu: wdata[16+LVL_W-1:16]};
  end

  thr_set_t [N_EV-1:0] sets_q, sets_d;

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    logic sel;
    assign sel = we && (addr == ADDR_W'(g));

    always_comb begin
      sets_d[g] = sets_q[g];
      if (sel) sets_d[g] = w_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sets_q[g] <= '0;
      else if (sel) sets_q[g] <= sets_d[g];
    end

    // stored priority and depth never exceed their ceilings
    assert_prio_clamped_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sets_q[g].prio <= PRIO_CAP) && (sets_q[g].cpu <= PCT_CAP));
  end

  logic [1:0][TEMP_W-1:0] thr_q, thr_d;
  logic [1:0]             thr_sel;

  for (genvar z = 0; z < 2; z++) begin : g_thr
    assign thr_sel[z] = we && (addr == ADDR_W'(N_EV + z));

    always_comb begin
      thr_d[z] = thr_q[z];
      if (thr_sel[z]) thr_d[z] = wdata[TEMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          thr_q[z] <= '1;
      else if (thr_sel[z]) thr_q[z] <= thr_d[z];
    end
  end

  assign sets_o = sets_q;
  assign thr_o  = thr_q;

endmodule

// File: rtl/thr_arb_zone.sv
module thr_arb_zone #(
  parameter int TEMP_W    = 18,
  parameter int HYST_MDEG = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] thr_i,
  output logic              hot_o
);

  localparam logic [TEMP_W-1:0] HYST = TEMP_W'(HYST_MDEG);

  logic [TEMP_W-1:0] rel_pt;
  logic              above, below, hot_q, hot_d;

  always_comb begin
    rel_pt = (thr_i > HYST) ? (thr_i - HYST) : '0;
    above  = temp_i > thr_i;
    below  = temp_i < rel_pt;
    hot_d  = hot_q;
    if (above)      hot_d = 1'b1;
    else if (below) hot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= hot_d;
  end

  assign hot_o = hot_q;

  assert_trip_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i > thr_i) |=> hot_q);

  assert_hold_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_q && !(temp_i < rel_pt)) |=> hot_q);

  assert_stay_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot_q && !(temp_i > thr_i)) |=> !hot_q);

endmodule

// File: rtl/thr_arb_pick.sv
module thr_arb_pick
  import thr_arb_pkg::*;
#(
  parameter int N_EV = 4
) (
  input  logic [N_EV-1:0]     act_i,
  input  thr_set_t [N_EV-1:0] sets_i,
  output logic                hit_o,
  output thr_set_t            win_o
);

  logic [PRIO_W-1:0] best;

  // strict compare keeps the lowest index on ties; zero priority never beats zero
  always_comb begin
    best  = '0;
    hit_o = 1'b0;
    win_o = '0;
    for (int i = 0; i < N_EV; i++) begin
      if (act_i[i] && (sets_i[i].prio > best)) begin
        best  = sets_i[i].prio;
        win_o = sets_i[i];
        hit_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/thr_arb.sv
module thr_arb
  import thr_arb_pkg::*;
#(
  parameter int N_OC      = 2,
  parameter int TEMP_W    = 18,
  parameter int HYST_MDEG = 1000,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int PRIO_MAX  = 100,
  parameter int PCT_MAX   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [TEMP_W-1:0] tz_light_temp,
  input  logic [TEMP_W-1:0] tz_heavy_temp,
  input  logic [N_OC-1:0]   oc_evt,
  output logic              thr_valid,
  output logic [PCT_W-1:0]  thr_cpu_pct,
  output logic [LVL_W-1:0]  thr_gpu_lvl
);

  localparam int N_EV = 2 + N_OC;

  // reset: asserts asynchronously, releases on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  thr_set_t [N_EV-1:0]    sets;
  logic [1:0][TEMP_W-1:0] thr;

  thr_arb_cfg #(
    .N_EV(N_EV), .TEMP_W(TEMP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRIO_MAX(PRIO_MAX), .PCT_MAX(PCT_MAX)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .sets_o(sets), .thr_o(thr)
  );

  logic [1:0][TEMP_W-1:0] temps;
  logic [1:0]             hot;
  assign temps = {tz_heavy_temp, tz_light_temp};

  for (genvar z = 0; z < 2; z++) begin : g_zone
    thr_arb_zone #(.TEMP_W(TEMP_W), .HYST_MDEG(HYST_MDEG)) u_zone (
      .clk(clk), .rst_n(rst_sync), .temp_i(temps[z]), .thr_i(thr[z]),
      .hot_o(hot[z])
    );
  end

  // event order: light, heavy, then overcurrent lines
  logic [N_EV-1:0] ev_act, ev_en;
  assign ev_act = {oc_evt, hot};
  for (genvar e = 0; e < N_EV; e++) begin : g_en
    assign ev_en[e] = (sets[e].prio != '0);
  end

  logic     hit;
  thr_set_t win;

  thr_arb_pick #(.N_EV(N_EV)) u_pick (
    .act_i(ev_act), .sets_i(sets), .hit_o(hit), .win_o(win)
  );

  logic             valid_d, valid_q;
  logic [PCT_W-1:0] cpu_d, cpu_q;
  logic [LVL_W-1:0] gpu_d, gpu_q;

  always_comb begin
    valid_d = hit;
    cpu_d   = hit ? win.cpu : '0;
    gpu_d   = hit ? win.gpu : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cpu_q   <= '0;
      gpu_q   <= '0;
    end else if (!rst_sync) begin
      valid_q <= 1'b0;
      cpu_q   <= '0;
      gpu_q   <= '0;
    end else begin
      valid_q <= valid_d;
      cpu_q   <= cpu_d;
      gpu_q   <= gpu_d;
    end
  end

  assign thr_valid   = valid_q;
  assign thr_cpu_pct = cpu_q;
  assign thr_gpu_lvl = gpu_q;

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    !thr_valid |-> (thr_cpu_pct == '0 && thr_gpu_lvl == '0));

  assert_valid_on_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    (|(ev_act & ev_en)) |=> thr_valid);

  assert_valid_off_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    !(|(ev_act & ev_en)) |=> !thr_valid);

  assert_cpu_range_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    thr_cpu_pct <= PCT_W'(PCT_MAX));

endmodule

// File: tb/thr_arb_bench.sv
module thr_arb_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [17:0] tl, th;
  logic [1:0]  oc;
  logic        v;
  logic [6:0]  cpu;
  logic [1:0]  gpu;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  thr_arb u_thr_arb (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tz_light_temp(tl), .tz_heavy_temp(th),
    .oc_evt(oc), .thr_valid(v), .thr_cpu_pct(cpu), .thr_gpu_lvl(gpu)
  );

  typedef struct packed {
    logic [17:0] tl;
    logic [17:0] th;
    logic [1:0]  oc;
    logic        ev;
    logic [6:0]  cpu;
    logic [1:0]  gpu;
  } vec_t;

  // light: prio 80 cpu 50 gpu 1 / heavy: 100,85,3 / oc0: 50,75,2 / oc1: 50,30,1
  // thresholds: light 90000, heavy 100000
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{18'd25000, 18'd25000,  2'b00, 1'b0, 7'd0,  2'd0},  // R5 idle
    '{18'd25000, 18'd25000,  2'b01, 1'b1, 7'd75, 2'd2},  // R8 oc0
    '{18'd25000, 18'd25000,  2'b10, 1'b1, 7'd30, 2'd1},  // R8 oc1
    '{18'd25000, 18'd25000,  2'b11, 1'b1, 7'd75, 2'd2},  // R3 tie
    '{18'd90000, 18'd25000,  2'b00, 1'b0, 7'd0,  2'd0},  // R6 equal, no trip
    '{18'd90001, 18'd25000,  2'b00, 1'b1, 7'd50, 2'd1},  // R6 trip
    '{18'd89500, 18'd25000,  2'b00, 1'b1, 7'd50, 2'd1},  // R7 band hold
    '{18'd89000, 18'd25000,  2'b00, 1'b1, 7'd50, 2'd1},  // R7 release point
    '{18'd88999, 18'd25000,  2'b00, 1'b0, 7'd0,  2'd0},  // R7 released
    '{18'd89500, 18'd25000,  2'b00, 1'b0, 7'd0,  2'd0},  // R7 band stays off
    '{18'd95000, 18'd100001, 2'b11, 1'b1, 7'd85, 2'd3},  // R2 heavy wins
    '{18'd95000, 18'd99500,  2'b11, 1'b1, 7'd85, 2'd3},  // R7 heavy held
    '{18'd95000, 18'd98000,  2'b01, 1'b1, 7'd50, 2'd1}   // R2 light over oc0
  };

  task automatic chk(input string req, input logic ev, input logic [6:0] ec,
                     input logic [1:0] eg);
    checks++;
    if (v !== ev || cpu !== ec || gpu !== eg) begin
      errors++;
      $display("FAIL %s: valid/cpu/gpu got %0b/%0d/%0d expected %0b/%0d/%0d",
               req, v, cpu, gpu, ev, ec, eg);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ev_word(input int p, input int c, input int g);
    return {14'd0, 2'(g), 1'b0, 7'(c), 1'b0, 7'(p)};
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tl = 18'd25000; th = 18'd25000; oc = 2'b00;
    repeat (2) @(negedge clk);
    chk("R9 reset state", 1'b0, 7'd0, 2'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: all disabled after reset, even with overcurrent active
    oc = 2'b11;
    settle();
    chk("R4 disabled after reset", 1'b0, 7'd0, 2'd0);
    oc = 2'b00;

    // R1 programming
    wr(3'd0, ev_word(80, 50, 1));
    wr(3'd1, ev_word(100, 85, 3));
    wr(3'd2, ev_word(50, 75, 2));
    wr(3'd3, ev_word(50, 30, 1));
    wr(3'd4, 32'd90000);
    wr(3'd5, 32'd100000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tl = VEC[i].tl; th = VEC[i].th; oc = VEC[i].oc;
      settle();
      chk($sformatf("R2/R3/R6/R7 vector %0d", i), VEC[i].ev, VEC[i].cpu, VEC[i].gpu);
    end

    // R1 clamping: oc1 written 127/127 becomes 100/100; tie with oc0 at 100
    wr(3'd2, ev_word(100, 75, 2));
    wr(3'd3, ev_word(127, 127, 1));
    tl = 18'd20000; th = 18'd20000; oc = 2'b11;
    settle();
    chk("R1 R3 clamped priority ties to lower index", 1'b1, 7'd75, 2'd2);
    oc = 2'b10;
    settle();
    chk("R1 cpu depth clamp", 1'b1, 7'd100, 2'd1);

    // R4: disabled event still hot
    oc = 2'b00;
    wr(3'd0, ev_word(0, 50, 1));
    tl = 18'd95000;
    settle();
    chk("R4 zero priority never wins", 1'b0, 7'd0, 2'd0);

    // R8 overcurrent: one edge
    @(negedge clk);
    oc = 2'b01;
    #4;
    chk("R8 oc before edge", 1'b0, 7'd0, 2'd0);
    @(negedge clk);
    chk("R8 oc after one edge", 1'b1, 7'd75, 2'd2);

    // R8 thermal: two edges
    oc = 2'b00;
    tl = 18'd20000;
    wr(3'd0, ev_word(80, 50, 1));
    settle();
    chk("R7 light cleared before latency test", 1'b0, 7'd0, 2'd0);
    tl = 18'd95000;
    @(negedge clk);
    chk("R8 thermal after one edge", 1'b0, 7'd0, 2'd0);
    @(negedge clk);
    chk("R8 thermal after two edges", 1'b1, 7'd50, 2'd1);

    // R9 mid-run reset clears outputs and configuration
    oc = 2'b01;
    settle();
    rst_n = 1'b0;
    #1;
    chk("R9 async clear", 1'b0, 7'd0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 config cleared", 1'b0, 7'd0, 2'd0);
    wr(3'd0, ev_word(80, 50, 1));
    settle();
    chk("R6 R9 threshold back to all ones", 1'b0, 7'd0, 2'd0);

    finish_run();
  end

endmodule